// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external, clock-free static RAM that holds 1M words of 8 bits. The host offers one access at a time: it presents an address, write data and a write flag with a request strobe while the controller signals it is ready. The controller then walks the memory through a fixed sequence of states. Each state lasts a number of clock cycles derived from nanosecond timing parameters and the clock period. When the access completes it raises a one-cycle done pulse, and after a read it holds the captured byte on its read-data output.

On the memory side the controller drives a 20-bit address, a pair of chip selects of opposite polarity (one active low, one active high), an active-low output enable and an active-low write enable. The 8-bit data bus is presented as separate outgoing data, an outgoing-drive enable and incoming data, so that the pad ring can build the bidirectional pins. After a read the controller waits out the memory's bus-release window before it may drive the bus again. During a write, address and data are held steady for the whole write-enable low period.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and right after it, the memory is deselected (memCeN=1, memCe2=0), memOeN=1, memWeN=1, memDoutEn=0, ready=1 and done=0.
- R2: The memory is only ever selected with memCeN=0 and memCe2=1 together. A mixed pair (both 0 or both 1) never appears, and between accesses the memory is deselected.
- R3: A read keeps the memory selected with memWeN=1 and memOeN=0 for RD cycles, where RD is the largest of ceil(tRC/Tclk), ceil(tAA/Tclk) and ceil(tOE/Tclk), each at least 1 (14 with defaults). The byte on memDin is captured at the end of that window. done is high for exactly one cycle, and rdData then shows the byte last written to that address.
- R4: A write drives memDoutEn=1 with memWeN=1 for exactly one setup cycle, then holds memWeN=0 for WP=max(1,ceil(tWP/Tclk)) cycles (12 with defaults), then keeps memWeN=1 with the driver still on for exactly one cycle before the driver is released.
- R5: While the memory is selected, memAddr does not change. While memWeN is low, memDout does not change either.
- R6: After memOeN rises at the end of a read, memDoutEn stays 0 for at least HZ=max(1,ceil(tHZ/Tclk)) cycles (7 with defaults).
- R7: ready is 1 only while no access is in progress, and in that state the memory is deselected. A request strobe while ready is 0 is ignored: it starts no access and changes no memory location.
- R8: The controller never drives the data bus while memOeN is 0, so it never contends with the memory's read output.
- R9: rdData keeps the last read byte until the next read completes; writes do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request strobe, taken when ready is 1 |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | 20 | Access address |
| reqWdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle pulse when an access completes |
| rdData | output | 8 | Byte captured by the last read |
| memAddr | output | 20 | Memory address pins |
| memCeN | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memDout | output | 8 | Data toward the memory |
| memDoutEn | output | 1 | Drive enable for memDout onto the pins |
| memDin | input | 8 | Data from the memory pins |

## Verification
A wrong state or a wrong count in the sequencer shows at the memory pins within the same access. A read window one cycle short samples the model's still-invalid data, so the returned byte is wrong at the done pulse. A shortened or skipped turnaround state makes the bench's bus model see both sides driving within the release window after a read. A write pulse of the wrong length, or a driver released together with write enable, shows in the measured pin timing and in the stored byte read back later. A request accepted while busy corrupts a location that a later read checks.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    sIdle,
    sRdAccess,
    sRdTurn,
    sWrSetup,
    sWrPulse,
    sWrHold
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic capture;
    logic driveBus;
  } dpStrobe_t;

  // clock cycles covering a time in picoseconds, never below one
  function automatic int cyclesFor(input int ps, input int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
`timescale 1ns/1ps
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int CLK_PS  = 4000,
  parameter int T_RC_PS = 55000,
  parameter int T_AA_PS = 55000,
  parameter int T_OE_PS = 30000,
  parameter int T_HZ_PS = 25000,
  parameter int T_WP_PS = 45000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      ready,
  output logic      done,
  output dpStrobe_t strobe,
  output logic      memCeN,
  output logic      memCe2,
  output logic      memOeN,
  output logic      memWeN
);

  localparam int RD_CYC  = maxOf3(cyclesFor(T_RC_PS, CLK_PS),
                                  cyclesFor(T_AA_PS, CLK_PS),
                                  cyclesFor(T_OE_PS, CLK_PS));
  localparam int HZ_CYC  = cyclesFor(T_HZ_PS, CLK_PS);
  localparam int WP_CYC  = cyclesFor(T_WP_PS, CLK_PS);
  localparam int MAX_CYC = maxOf3(RD_CYC, HZ_CYC, WP_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctlState_e        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             cntZero;
  logic             selected;

  assign cntZero = (cnt == '0);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      sIdle: begin
        if (reqValid) begin
          if (reqWrite) begin
            nextState = sWrSetup;
          end else begin
            nextState = sRdAccess;
            nextCnt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      sRdAccess: begin
        if (cntZero) begin
          nextState = sRdTurn;
          nextCnt   = CNT_W'(HZ_CYC - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      sRdTurn: begin
        if (cntZero) nextState = sIdle;
        else         nextCnt   = cnt - 1'b1;
      end
      sWrSetup: begin
        nextState = sWrPulse;
        nextCnt   = CNT_W'(WP_CYC - 1);
      end
      sWrPulse: begin
        if (cntZero) nextState = sWrHold;
        else         nextCnt   = cnt - 1'b1;
      end
      sWrHold: nextState = sIdle;
      default: nextState = sIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= sIdle;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      done  <= strobe.capture || (state == sWrHold);
    end
  end

  assign selected = (state == sRdAccess) || (state == sWrSetup) ||
                    (state == sWrPulse)  || (state == sWrHold);

  always_comb begin
    strobe.loadReq  = (state == sIdle) && reqValid;
    strobe.capture  = (state == sRdAccess) && cntZero;
    strobe.driveBus = (state == sWrSetup) || (state == sWrPulse) ||
                      (state == sWrHold);
  end

  assign ready  = (state == sIdle);
  assign memCeN = !selected;
  assign memCe2 = selected;
  assign memOeN = (state != sRdAccess);
  assign memWeN = (state != sWrPulse);

endmodule

// File: rtl/asram_ctrl_dp.sv
`timescale 1ns/1ps
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
    end else if (strobe.loadReq) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdReg <= '0;
    else if (strobe.capture) rdReg <= memDin;
  end

  assign memAddr   = addrReg;
  assign memDout   = wdataReg;
  assign memDoutEn = strobe.driveBus;
  assign rdData    = rdReg;

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int CLK_PS  = 4000,
  parameter int T_RC_PS = 55000,
  parameter int T_AA_PS = 55000,
  parameter int T_OE_PS = 30000,
  parameter int T_HZ_PS = 25000,
  parameter int T_WP_PS = 45000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe2,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  dpStrobe_t strobe;

  asram_ctrl_fsm #(
    .CLK_PS (CLK_PS),
    .T_RC_PS(T_RC_PS),
    .T_AA_PS(T_AA_PS),
    .T_OE_PS(T_OE_PS),
    .T_HZ_PS(T_HZ_PS),
    .T_WP_PS(T_WP_PS)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .ready   (ready),
    .done    (done),
    .strobe  (strobe),
    .memCeN  (memCeN),
    .memCe2  (memCe2),
    .memOeN  (memOeN),
    .memWeN  (memWeN)
  );

  asram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDin   (memDin),
    .memAddr  (memAddr),
    .memDout  (memDout),
    .memDoutEn(memDoutEn),
    .rdData   (rdData)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 8,
  parameter int CLK_PS  = 4000,
  parameter int T_HZ_PS = 25000
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memCe2,
  input logic              memOeN,
  input logic              memWeN,
  input logic [DATA_W-1:0] memDout,
  input logic              memDoutEn
);

  localparam int HZ_CYC = cyclesFor(T_HZ_PS, CLK_PS);

  // cycles since the memory output enable was last released
  int relCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               relCnt <= HZ_CYC;
    else if (!memOeN)        relCnt <= 0;
    else if (relCnt < HZ_CYC) relCnt <= relCnt + 1;
  end

  p_sel_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    memCeN != memCe2);

  p_idle_deselect_r7: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (memCeN && !memDoutEn));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_release_after_we_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memDoutEn) |-> (memWeN && $past(memWeN)));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  p_wdata_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memDout));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDoutEn) |-> (relCnt >= HZ_CYC));

  p_no_contend_r8: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> memOeN);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CLK_PS (CLK_PS),
  .T_HZ_PS(T_HZ_PS)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ready    (ready),
  .done     (done),
  .memAddr  (memAddr),
  .memCeN   (memCeN),
  .memCe2   (memCe2),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memDout  (memDout),
  .memDoutEn(memDoutEn)
);

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;

  // expected timing in cycles at 4 ns: read 14, release 7, write pulse 12
  localparam int EXP_RD = 14;
  localparam int EXP_HZ = 7;
  localparam int EXP_WP = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ready, done;
  logic [7:0]  rdData;
  logic [19:0] memAddr;
  logic        memCeN, memCe2, memOeN, memWeN;
  logic [7:0]  memDout;
  logic        memDoutEn;
  logic [7:0]  memDin;

  always #2 clk = ~clk;

  asram_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .done(done),
    .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN), .memCe2(memCe2),
    .memOeN(memOeN), .memWeN(memWeN), .memDout(memDout),
    .memDoutEn(memDoutEn), .memDin(memDin)
  );

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model, 1 ns ticks ----------------
  logic [7:0] modelMem [int];
  logic       modelDrv = 1'b0;
  logic [7:0] modelOut = '0;
  int         contention = 0;
  int         addrAge = 0, selAge = 0, oeAge = 0, relAge = 100;
  logic [19:0] prevAddr = '0;
  logic       prevWriting = 1'b0;
  logic [19:0] wrAddrLatch = '0;
  logic [7:0] wrDataLatch = '0;
  logic [7:0] bus;

  assign bus    = memDoutEn ? memDout : (modelDrv ? modelOut : 8'h00);
  assign memDin = bus;

  task automatic modelTick();
    logic sel, rdCond, writing;
    logic [7:0] stored;
    sel     = !memCeN && memCe2;
    rdCond  = sel && memWeN && !memOeN;
    writing = sel && !memWeN;
    if (memAddr != prevAddr) addrAge = 0; else if (addrAge < 1000) addrAge++;
    prevAddr = memAddr;
    if (!sel) selAge = 0; else if (selAge < 1000) selAge++;
    if (!rdCond) oeAge = 0; else if (oeAge < 1000) oeAge++;
    stored = modelMem.exists(int'(memAddr)) ? modelMem[int'(memAddr)] : 8'h00;
    if (rdCond) begin
      relAge   = 0;
      modelDrv = 1'b1;
      if (addrAge >= 55 && selAge >= 55 && oeAge >= 30) modelOut = stored;
      else modelOut = stored ^ 8'hC3;
    end else if (relAge < 25) begin
      relAge++;
      modelDrv = 1'b1;
      modelOut = 8'h96;
    end else begin
      modelDrv = 1'b0;
    end
    if (modelDrv && memDoutEn) contention++;
    if (writing) begin
      wrAddrLatch = memAddr;
      wrDataLatch = bus;
    end
    if (prevWriting && !writing) modelMem[int'(wrAddrLatch)] = wrDataLatch;
    prevWriting = writing;
  endtask

  initial begin
    #0.5;
    forever begin
      modelTick();
      #1;
    end
  end

  // ---------------- pin-timing monitor at negedges ----------------
  int oeRun = 0, lastOeLow = 0, weRun = 0, lastWeLow = 0;
  int setupCnt = 0, holdCnt = 0, gapCnt = 0, lastGap = 0;
  int doubleDone = 0, badSel = 0, busyReadyHigh = 0;
  bit sawWeLow = 0, prevDoutEn = 0, prevDone = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memOeN) oeRun++;
      else if (oeRun != 0) begin lastOeLow = oeRun; oeRun = 0; end
      if (!memWeN) weRun++;
      else if (weRun != 0) begin lastWeLow = weRun; weRun = 0; end
      if (memDoutEn && !prevDoutEn) begin
        setupCnt = 0; holdCnt = 0; sawWeLow = 0; lastGap = gapCnt;
      end
      if (memDoutEn) begin
        if (!memWeN) sawWeLow = 1;
        else if (!sawWeLow) setupCnt++;
        else holdCnt++;
      end
      if (!memOeN) gapCnt = 0;
      else if (!memDoutEn) gapCnt++;
      if (done && prevDone) doubleDone++;
      if (memCeN == memCe2) badSel++;
      if (ready && !memCeN) busyReadyHigh++;
      prevDoutEn = memDoutEn;
      prevDone   = done;
    end
  end

  // ---------------- host access task ----------------
  task automatic doAccess(input logic wr, input logic [19:0] a,
                          input logic [7:0] d, output logic [7:0] rd,
                          output int doneWidth);
    int guard;
    @(negedge clk);
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin @(negedge clk); guard++; end
    rd = rdData;
    doneWidth = 0;
    while (done && doneWidth < 5) begin doneWidth++; @(negedge clk); end
  endtask

  // wr, addr, data (write data or expected read byte)
  localparam logic [28:0] VEC [10] = '{
    {1'b1, 20'h00000, 8'hA5},
    {1'b1, 20'hFFFFF, 8'h3C},
    {1'b1, 20'h12345, 8'h00},
    {1'b1, 20'h00001, 8'hFF},
    {1'b0, 20'h00000, 8'hA5},
    {1'b0, 20'hFFFFF, 8'h3C},
    {1'b0, 20'h12345, 8'h00},
    {1'b0, 20'h00001, 8'hFF},
    {1'b1, 20'h00000, 8'h5A},
    {1'b0, 20'h00000, 8'h5A}
  };

  initial begin
    logic [7:0] rd;
    int dw;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ceN in reset", memCeN, 1);
    chk("R1 ce2 in reset", memCe2, 0);
    chk("R1 oeN/weN in reset", {memOeN, memWeN}, 2'b11);
    chk("R1 doutEn in reset", memDoutEn, 0);
    chk("R1 ready/done in reset", {ready, done}, 2'b10);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {memCeN, memCe2, memOeN, memWeN, memDoutEn, ready, done},
        7'b1011010);

    // vector table
    foreach (VEC[i]) begin
      doAccess(VEC[i][28], VEC[i][27:8], VEC[i][7:0], rd, dw);
      if (!VEC[i][28]) begin
        chk($sformatf("R3 read data vec %0d", i), rd, VEC[i][7:0]);
        chk("R3 read window cycles", lastOeLow, EXP_RD);
      end else begin
        chk($sformatf("R4 write pulse cycles vec %0d", i), lastWeLow, EXP_WP);
      end
      chk("R3 done width", dw, 1);
    end
    chk("R4 write setup cycles", setupCnt, 1);
    chk("R4 write hold cycles", holdCnt, 1);

    // R9: write leaves rdData alone (last read returned 5A)
    doAccess(1'b1, 20'h00777, 8'h81, rd, dw);
    chk("R9 rdData after write", rd, 8'h5A);

    // R6: read followed at once by a write
    doAccess(1'b0, 20'h00777, 8'h81, rd, dw);
    chk("R3 read after write", rd, 8'h81);
    doAccess(1'b1, 20'h00800, 8'h42, rd, dw);
    chk("R6 turnaround at least HZ", (lastGap >= EXP_HZ) ? 1 : 0, 1);
    if (lastGap < EXP_HZ) $display("FAIL R6 gap actual=%0d expected>=%0d", lastGap, EXP_HZ);

    // R7: request while busy is ignored
    doAccess(1'b1, 20'h00900, 8'h11, rd, dw);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 20'h00A00; reqWdata = 8'h22;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 ready low while busy", ready, 0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 20'h00900; reqWdata = 8'hEE;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    while (!ready) @(negedge clk);
    doAccess(1'b0, 20'h00900, 8'h00, rd, dw);
    chk("R7 ignored request left location", rd, 8'h11);
    doAccess(1'b0, 20'h00A00, 8'h00, rd, dw);
    chk("R7 accepted write stored", rd, 8'h22);

    // R8 / R2 / R3 global observations
    chk("R8 bus contention ticks", contention, 0);
    chk("R2 mixed select cycles", badSel, 0);
    chk("R7 ready while selected", busyReadyHigh, 0);
    chk("R3 done longer than one cycle", doubleDone, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule